// File: doc/BRIEF.md
# Multiplexed Audio Serial Frame Codec

This block packs and unpacks one bit-serial audio link that runs on a single bit clock. The clock runs at 256 times the base sample rate. In each base-rate period the link carries one frame of ten 24-bit slots. Two slots hold the left and right 24-bit PCM samples. The other eight slots each hold 16 one-bit audio samples in their upper bits and an 8-bit status/control byte in their low bits. Each channel gets four such slots, which gives 64 one-bit samples per channel per base period.

A single-cycle frame-sync pulse starts a frame in both directions. On the transmit side, all parallel words are captured at the sync edge. The 240 payload bits are then shifted out MSB first, and the line stays low for the rest of the 256-period frame. On the receive side, the bits that follow the sync are collected. When the last bit of the tenth slot arrives, the block updates its parallel PCM, stream-word and status outputs together and raises a one-cycle frame-valid strobe. A sync that arrives early restarts both directions and drops the partial receive frame. Clock generation is outside this block.

Top module: `afc_codec`

## Requirements
- R1: After reset, serOut is 0, rxFrameValid is 0, and all parallel receive outputs are 0.
- R2: If frameSync is sampled high at clock edge k, then serOut during the cycle after edge k+p carries frame bit p, for p = 0 to 239. Each slot is sent MSB first. Slot 0 is txPcmL and slot 1 is txPcmR.
- R3: Slots 2 to 9 carry stream index j = 0 to 7, in the order L1, R1, L2, R2, L3, R3, L4, R4. Stream j is taken from txStreamWords[16j+15:16j] and txStatus[8j+7:8j]. Each of these slots is sent as {16-bit word, 8-bit status}.
- R4: The transmit words are captured at the sync edge. Changes to the tx inputs during a frame do not alter the bits sent in that frame.
- R5: After frame bit 239 has been sent, serOut stays 0 until the next frameSync.
- R6: The receiver samples serIn at edge k+p+1 as frame bit p. At the edge that samples bit 239, rxPcmL and rxPcmR are updated from slots 0 and 1. rxFrameValid is high in the following cycle, for exactly one cycle.
- R7: For each slot 2 to 9, the receiver places the upper 16 bits in rxStreamWords[16j+15:16j] and the low 8 bits in rxStatus[8j+7:8j], with the same stream index j as in R3.
- R8: All receive outputs hold their values between frame-valid strobes.
- R9: A frameSync that comes fewer than 240 bit periods after the previous one restarts both directions. The partial receive frame produces no rxFrameValid and changes no output.
- R10: serIn values sampled after bit 239 of a frame, and before the next sync, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frameSync | input | 1 | Single-cycle frame start pulse |
| serIn | input | 1 | Receive serial data |
| txPcmL | input | 24 | Left PCM sample to send |
| txPcmR | input | 24 | Right PCM sample to send |
| txStreamWords | input | 128 | Eight 16-bit one-bit-audio words to send, index 0 in the low bits |
| txStatus | input | 64 | Eight status bytes to send, index 0 in the low bits |
| serOut | output | 1 | Transmit serial data |
| rxPcmL | output | 24 | Received left PCM sample |
| rxPcmR | output | 24 | Received right PCM sample |
| rxStreamWords | output | 128 | Received one-bit-audio words |
| rxStatus | output | 64 | Received status bytes |
| rxFrameValid | output | 1 | One-cycle strobe after a complete receive frame |

## Verification
The main tests loop serOut back to serIn with distinct per-slot values, all-ones and random words. These patterns catch a wrong slot order, a wrong bit order within a slot, and a swapped payload and status byte. Separate frames drive serIn randomly, independent of the transmitter, so that receive faults cannot hide behind matching transmit faults. Several frames change the tx words in mid-frame or drive ones during the idle gap, which tells capture-at-sync and gap-ignoring apart from live sampling. Short frames and back-to-back 240-period frames exercise realignment and the case where a sync lands exactly on the completing edge.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int SLOT_W      = 24;
  localparam int NUM_SLOTS   = 10;
  localparam int PAY_W       = 16;
  localparam int STAT_W      = SLOT_W - PAY_W;
  localparam int NUM_STREAM  = NUM_SLOTS - 2;
  localparam int ACTIVE_BITS = SLOT_W * NUM_SLOTS;
  localparam int CNT_W       = $clog2(ACTIVE_BITS);

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txOn;
    logic rxShift;
    logic rxDone;
  } strobes_t;
endpackage

// File: rtl/afc_ctrl.sv
module afc_ctrl
  import afc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frameSync,
  output strobes_t strb
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACTIVE_BITS - 1);

  logic [CNT_W-1:0] txCnt, rxCnt;
  logic txActive, rxActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      txActive <= 1'b0;
      txCnt    <= '0;
      rxActive <= 1'b0;
      rxCnt    <= '0;
    end else begin
      if (frameSync) begin
        txActive <= 1'b1;
        txCnt    <= '0;
      end else if (txActive) begin
        if (txCnt == LAST) txActive <= 1'b0;
        txCnt <= txCnt + 1'b1;
      end
      if (frameSync) begin
        rxActive <= 1'b1;
        rxCnt    <= '0;
      end else if (rxActive) begin
        if (rxCnt == LAST) rxActive <= 1'b0;
        rxCnt <= rxCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.txLoad  = frameSync;
    strb.txShift = txActive && !frameSync;
    strb.txOn    = txActive;
    strb.rxShift = rxActive;
    strb.rxDone  = rxActive && (rxCnt == LAST);
  end

  AST_SYNC_REALIGN: assert property (@(posedge clk) disable iff (rst)
    frameSync |=> txActive && rxActive && txCnt == '0 && rxCnt == '0); // R9
  AST_TX_ENDS: assert property (@(posedge clk) disable iff (rst)
    txActive && txCnt == LAST && !frameSync |=> !txActive); // R5
  AST_RX_STEP: assert property (@(posedge clk) disable iff (rst)
    rxActive && !frameSync && rxCnt != LAST |=> rxActive && rxCnt == $past(rxCnt) + 1'b1); // R6
endmodule

// File: rtl/afc_datapath.sv
module afc_datapath
  import afc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  strobes_t                     strb,
  input  logic                         serIn,
  input  logic [SLOT_W-1:0]            txPcmL,
  input  logic [SLOT_W-1:0]            txPcmR,
  input  logic [PAY_W*NUM_STREAM-1:0]  txStreamWords,
  input  logic [STAT_W*NUM_STREAM-1:0] txStatus,
  output logic                         serOut,
  output logic [SLOT_W-1:0]            rxPcmL,
  output logic [SLOT_W-1:0]            rxPcmR,
  output logic [PAY_W*NUM_STREAM-1:0]  rxStreamWords,
  output logic [STAT_W*NUM_STREAM-1:0] rxStatus,
  output logic                         rxFrameValid
);
  logic [ACTIVE_BITS-1:0] txFrame, txSh, rxHold;
  logic [ACTIVE_BITS-2:0] rxSh;

  always_comb begin
    txFrame = '0;
    txFrame[ACTIVE_BITS-1 -: SLOT_W]        = txPcmL;
    txFrame[ACTIVE_BITS-1-SLOT_W -: SLOT_W] = txPcmR;
    for (int j = 0; j < NUM_STREAM; j++) begin
      txFrame[ACTIVE_BITS-1-SLOT_W*(j+2) -: SLOT_W] =
        {txStreamWords[PAY_W*j +: PAY_W], txStatus[STAT_W*j +: STAT_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txSh <= '0;
    end else if (strb.txLoad) begin
      txSh <= txFrame;
    end else if (strb.txShift) begin
      txSh <= {txSh[ACTIVE_BITS-2:0], 1'b0};
    end
  end

  assign serOut = strb.txOn & txSh[ACTIVE_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rxSh         <= '0;
      rxHold       <= '0;
      rxFrameValid <= 1'b0;
    end else begin
      if (strb.rxShift) rxSh <= {rxSh[ACTIVE_BITS-3:0], serIn};
      if (strb.rxDone) rxHold <= {rxSh, serIn};
      rxFrameValid <= strb.rxDone;
    end
  end

  assign rxPcmL = rxHold[ACTIVE_BITS-1 -: SLOT_W];
  assign rxPcmR = rxHold[ACTIVE_BITS-1-SLOT_W -: SLOT_W];

  for (genvar j = 0; j < NUM_STREAM; j++) begin : g_unpack
    localparam int TOP = ACTIVE_BITS - 1 - SLOT_W * (j + 2);
    assign rxStreamWords[PAY_W*j +: PAY_W] = rxHold[TOP -: PAY_W];
    assign rxStatus[STAT_W*j +: STAT_W]    = rxHold[TOP-PAY_W -: STAT_W];
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rxFrameValid |=> !rxFrameValid); // R6
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rxFrameValid |-> $stable(rxHold)); // R8
endmodule

// File: rtl/afc_codec.sv
module afc_codec
  import afc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frameSync,
  input  logic                         serIn,
  input  logic [SLOT_W-1:0]            txPcmL,
  input  logic [SLOT_W-1:0]            txPcmR,
  input  logic [PAY_W*NUM_STREAM-1:0]  txStreamWords,
  input  logic [STAT_W*NUM_STREAM-1:0] txStatus,
  output logic                         serOut,
  output logic [SLOT_W-1:0]            rxPcmL,
  output logic [SLOT_W-1:0]            rxPcmR,
  output logic [PAY_W*NUM_STREAM-1:0]  rxStreamWords,
  output logic [STAT_W*NUM_STREAM-1:0] rxStatus,
  output logic                         rxFrameValid
);
  strobes_t strb;

  afc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .frameSync(frameSync), .strb(strb)
  );

  afc_datapath u_dp (
    .clk(clk), .rst(rst), .strb(strb), .serIn(serIn),
    .txPcmL(txPcmL), .txPcmR(txPcmR), .txStreamWords(txStreamWords), .txStatus(txStatus),
    .serOut(serOut), .rxPcmL(rxPcmL), .rxPcmR(rxPcmR), .rxStreamWords(rxStreamWords),
    .rxStatus(rxStatus), .rxFrameValid(rxFrameValid)
  );
endmodule

// File: tb/afc_codec_test.sv
`timescale 1ns/1ps
module afc_codec_test;
  logic clk = 1'b0, rst = 1'b1, frameSync = 1'b0, serIn = 1'b0;
  logic [23:0] txPcmL = '0, txPcmR = '0;
  logic [127:0] txStreamWords = '0;
  logic [63:0] txStatus = '0;
  logic serOut, rxFrameValid;
  logic [23:0] rxPcmL, rxPcmR;
  logic [127:0] rxStreamWords;
  logic [63:0] rxStatus;

  int checks = 0, errors = 0, dutValids = 0;

  afc_codec uut (
    .clk(clk), .rst(rst), .frameSync(frameSync), .serIn(serIn),
    .txPcmL(txPcmL), .txPcmR(txPcmR), .txStreamWords(txStreamWords), .txStatus(txStatus),
    .serOut(serOut), .rxPcmL(rxPcmL), .rxPcmR(rxPcmR), .rxStreamWords(rxStreamWords),
    .rxStatus(rxStatus), .rxFrameValid(rxFrameValid)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (!rst && rxFrameValid) dutValids++;

  // reference model state
  int txPos = -1, rxPos = -1;
  bit txBits [240];
  bit rxBits [$];
  logic expSer = 1'b0, expValid = 1'b0;
  logic [23:0] expPcmL = '0, expPcmR = '0;
  logic [127:0] expStream = '0;
  logic [63:0] expStatus = '0;

  function automatic logic [23:0] slotVal(int s);
    if (s == 0) return txPcmL;
    if (s == 1) return txPcmR;
    return {txStreamWords[16*(s-2) +: 16], txStatus[8*(s-2) +: 8]};
  endfunction

  function automatic logic [23:0] rxSlot(int s);
    logic [23:0] v = '0;
    for (int i = 0; i < 24; i++) v[23-i] = rxBits[24*s+i];
    return v;
  endfunction

  task automatic modelStep(input bit sync, input bit sin);
    if (sync) begin
      for (int s = 0; s < 10; s++) begin
        logic [23:0] v;
        v = slotVal(s);
        for (int i = 0; i < 24; i++) txBits[24*s+i] = v[23-i];
      end
      txPos = 0;
    end else if (txPos >= 0) begin
      txPos++;
      if (txPos == 240) txPos = -1;
    end
    expSer = (txPos >= 0) ? txBits[txPos] : 1'b0;
    expValid = 1'b0;
    if (rxPos >= 0) begin
      rxBits.push_back(sin);
      rxPos++;
      if (rxPos == 240) begin
        expPcmL = rxSlot(0);
        expPcmR = rxSlot(1);
        for (int j = 0; j < 8; j++) begin
          logic [23:0] v;
          v = rxSlot(j + 2);
          expStream[16*j +: 16] = v[23:8];
          expStatus[8*j +: 8]   = v[7:0];
        end
        expValid = 1'b1;
        rxPos = -1;
      end
    end
    if (sync) begin
      rxPos = 0;
      rxBits.delete();
    end
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    if (txPos < 0)       check("R5 serOut idle", 128'(serOut), 128'(expSer));
    else if (txPos < 48) check("R2 serOut pcm", 128'(serOut), 128'(expSer));
    else                 check("R3 serOut stream", 128'(serOut), 128'(expSer));
    check("R6 rxFrameValid", 128'(rxFrameValid), 128'(expValid));
    if (expValid) begin
      check("R6 rxPcmL", 128'(rxPcmL), 128'(expPcmL));
      check("R6 rxPcmR", 128'(rxPcmR), 128'(expPcmR));
      check("R7 rxStreamWords", rxStreamWords, expStream);
      check("R7 rxStatus", 128'(rxStatus), 128'(expStatus));
    end else begin
      check("R8 rxPcmL hold", 128'(rxPcmL), 128'(expPcmL));
      check("R8 rxPcmR hold", 128'(rxPcmR), 128'(expPcmR));
      check("R8 rxStreamWords hold", rxStreamWords, expStream);
      check("R8 rxStatus hold", 128'(rxStatus), 128'(expStatus));
    end
  endtask

  task automatic tick(input bit sync, input bit sin);
    @(negedge clk);
    frameSync = sync;
    serIn = sin;
    modelStep(sync, sin);
    @(posedge clk);
    #1;
    compareAll();
  endtask

  task automatic randomTx();
    txPcmL = 24'($urandom);
    txPcmR = 24'($urandom);
    txStreamWords = {$urandom, $urandom, $urandom, $urandom};
    txStatus = {$urandom, $urandom};
  endtask

  // mode 0: loop back, mode 1: random serIn
  task automatic runFrame(input int len, input int mode, input int changeAt, input bit idleOnes);
    for (int c = 0; c < len; c++) begin
      bit sin;
      if (c == changeAt) randomTx();
      sin = (mode == 0) ? bit'(expSer) : bit'($urandom & 1);
      if (idleOnes && c > 240) sin = 1'b1;
      tick(c == 0, sin);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] p1L, p1R;
    logic [127:0] p1S;
    logic [63:0] p1T;
    int v0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 serOut reset", 128'(serOut), 128'(0));
    check("R1 rxFrameValid reset", 128'(rxFrameValid), 128'(0));
    check("R1 rxPcmL reset", 128'(rxPcmL), 128'(0));
    check("R1 rxStreamWords reset", rxStreamWords, 128'(0));
    repeat (3) tick(1'b0, 1'b1);

    // distinct per-slot pattern, changed mid-frame, ones in the idle gap
    txPcmL = 24'hA5C30F; txPcmR = 24'h5A3CF0;
    for (int j = 0; j < 8; j++) begin
      txStreamWords[16*j +: 16] = 16'h1000 * 16'(j + 1) + 16'h0F81;
      txStatus[8*j +: 8] = 8'h10 + 8'(j);
    end
    p1L = txPcmL; p1R = txPcmR; p1S = txStreamWords; p1T = txStatus;
    runFrame(256, 0, 60, 1'b1);
    check("R4 captured pcmL", 128'(rxPcmL), 128'(p1L));
    check("R3 stream words in slots", rxStreamWords, p1S);
    check("R3 status in slots", 128'(rxStatus), 128'(p1T));
    check("R10 idle ones ignored", 128'(rxPcmR), 128'(p1R));

    // all ones
    txPcmL = '1; txPcmR = '1; txStreamWords = '1; txStatus = '1;
    runFrame(256, 0, -1, 1'b0);

    // short frame then realign
    randomTx();
    v0 = dutValids;
    runFrame(100, 1, -1, 1'b0);
    check("R9 no valid from partial frame", 128'(dutValids), 128'(v0));
    runFrame(240, 0, 30, 1'b0);
    runFrame(240, 0, -1, 1'b0);
    runFrame(256, 1, 200, 1'b1);

    for (int f = 0; f < 6; f++) begin
      randomTx();
      runFrame(240 + 4 * f, f % 2, 100 + f, f[0]);
    end
    repeat (20) tick(1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule